// File: doc/BRIEF.md
# Look-Ahead Bank Command Scheduler

This block sits between an in-order read request queue and a four-bank DDR2-style memory. It picks exactly one memory command (precharge, activate, read or idle) per clock cycle. Each request names a bank, a row, a starting column and a burst count. The oldest request is always served first and is the only one allowed to read. A request whose row is already open reads at once. Any other request first closes the bank's open row, then opens the target row, then reads.

Waiting for a timing gap wastes bus cycles. Whenever the oldest request is stalled, the scheduler looks at the younger entries and issues an early precharge or activate on behalf of one of them. It favours the entry closest to the head that is legal right now. Rows that an older pending request still relies on are never closed early. Per-bank down-counters enforce the precharge-to-activate and activate-to-read delays, and a shared counter spaces reads.

Top module: `bank_lookahead_sched`

## Requirements
- R1: After reset the command output is idle (code 0, bank 0, address 0) and `reqReady` is high.
- R2: A head request whose bank has its target row open is served by READ commands only, with no precharge or activate.
- R3: A head request to a bank with a different open row gets PRE, then ACT, then READ. A request to a closed bank gets ACT, then READ. PRE is only sent to an open bank.
- R4: An ACT to a bank comes no sooner than T_RP cycles (default 2) after a PRE to that bank.
- R5: A READ comes no sooner than T_RCD cycles (default 2) after the ACT of its bank, and only to the open target row.
- R6: A request with N bursts (`reqBursts` = N-1) issues N READs exactly T_RR = 2 cycles apart. The column starts at `reqCol` and grows by 4 per READ.
- R7: While the head is stalled, the oldest younger entry with a legal PRE or ACT issues it. A younger entry that is blocked by timing gives way to the next eligible one.
- R8: Only the head issues READs, so READs come out in arrival order. An entry retires with its last READ.
- R9: No early command touches a bank for which an older pending entry targets a different row.
- R10: The queue holds 4 entries. `reqReady` falls when all are valid, and a push happens when `reqValid` and `reqReady` are both high.
- R11: Each cycle carries at most one command, and the code is NOP (0) when nothing is legal. Command codes are NOP=0, PRE=1, ACT=2, READ=3. The address is the row on ACT, the column on READ, and 0 on PRE and NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Queue has a free entry |
| reqBank | input | 2 | Target bank |
| reqRow | input | 8 | Target row |
| reqCol | input | 8 | Starting column |
| reqBursts | input | 2 | Number of READ bursts minus one |
| cmdCode | output | 2 | Command this cycle: 0 NOP, 1 PRE, 2 ACT, 3 READ |
| cmdBank | output | 2 | Bank of the command |
| cmdAddr | output | 8 | Row on ACT, column on READ, else 0 |

## Verification
The assertions take for granted that a request is held stable while `reqValid` is high and `reqReady` is low, and that every bank and row value pushed is in range. They also assume the timing parameters are at least 1. The directed stimulus only changes request fields on the falling edge after a push has been accepted. It sets up open rows with ordinary requests and lets the block go idle before each measured sequence, so every expected command cycle follows from known bank state.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_ACT = 2'd2,
    CMD_RD  = 2'd3
  } cmd_e;

  // decision passed from the control to the datapath each cycle
  typedef struct packed {
    logic issue;
    cmd_e code;
    logic retire;
  } strobe_t;
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int NUM_BANKS  = 4,
  parameter int ROW_W      = 8,
  parameter int MAX_BURSTS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int LEFT_W = $clog2(MAX_BURSTS)
) (
  input  logic [DEPTH-1:0]                 qValid,
  input  logic [DEPTH-1:0][BANK_W-1:0]     qBank,
  input  logic [DEPTH-1:0][ROW_W-1:0]      qRow,
  input  logic [DEPTH-1:0][LEFT_W-1:0]     qLeft,
  input  logic [NUM_BANKS-1:0]             bankOpen,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]  bankRow,
  input  logic [NUM_BANKS-1:0]             bankBusy,
  input  logic                             rdBusy,
  output strobe_t                          strb,
  output logic [SLOT_W-1:0]                slot
);
  cmd_e             need [DEPTH];
  logic [DEPTH-1:0] hit;
  logic [DEPTH-1:0] timeOk;
  logic [DEPTH-1:0] clash;

  // per-entry next command and whether timing allows it now
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit[i]    = bankOpen[qBank[i]] && (bankRow[qBank[i]] == qRow[i]);
      need[i]   = hit[i] ? CMD_RD : (bankOpen[qBank[i]] ? CMD_PRE : CMD_ACT);
      timeOk[i] = !bankBusy[qBank[i]] && !(hit[i] && rdBusy);
      clash[i]  = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j < i && qValid[j] && qBank[j] == qBank[i] && qRow[j] != qRow[i])
          clash[i] = 1'b1;
      end
    end
  end

  // head first, then the oldest legal early PRE/ACT
  always_comb begin
    logic found;
    strb  = '0;
    slot  = '0;
    found = 1'b0;
    if (qValid[0] && timeOk[0]) begin
      strb.issue  = 1'b1;
      strb.code   = need[0];
      strb.retire = (need[0] == CMD_RD) && (qLeft[0] == '0);
    end else begin
      for (int i = 1; i < DEPTH; i++) begin
        if (!found && qValid[i] && need[i] != CMD_RD && timeOk[i] && !clash[i]) begin
          found      = 1'b1;
          strb.issue = 1'b1;
          strb.code  = need[i];
          slot       = SLOT_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/sched_dp.sv
module sched_dp
  import sched_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int NUM_BANKS  = 4,
  parameter int ROW_W      = 8,
  parameter int COL_W      = 8,
  parameter int MAX_BURSTS = 4,
  parameter int BURST_LEN  = 4,
  parameter int T_RP       = 2,
  parameter int T_RCD      = 2,
  parameter int T_RR       = 2,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int LEFT_W = $clog2(MAX_BURSTS),
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int MAX_T  = (T_RP > T_RCD) ? ((T_RP > T_RR) ? T_RP : T_RR)
                                         : ((T_RCD > T_RR) ? T_RCD : T_RR),
  localparam int CNT_W  = $clog2(MAX_T + 1)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             reqValid,
  output logic                             reqReady,
  input  logic [BANK_W-1:0]                reqBank,
  input  logic [ROW_W-1:0]                 reqRow,
  input  logic [COL_W-1:0]                 reqCol,
  input  logic [LEFT_W-1:0]                reqBursts,
  input  strobe_t                          strb,
  input  logic [SLOT_W-1:0]                slot,
  output logic [DEPTH-1:0]                 qValid,
  output logic [DEPTH-1:0][BANK_W-1:0]     qBank,
  output logic [DEPTH-1:0][ROW_W-1:0]      qRow,
  output logic [DEPTH-1:0][LEFT_W-1:0]     qLeft,
  output logic [NUM_BANKS-1:0]             bankOpen,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]  bankRow,
  output logic [NUM_BANKS-1:0]             bankBusy,
  output logic                             rdBusy,
  output cmd_e                             cmdCode,
  output logic [BANK_W-1:0]                cmdBank,
  output logic [ADDR_W-1:0]                cmdAddr
);
  logic [DEPTH-1:0][COL_W-1:0]    qCol;
  logic [DEPTH-1:0]               nValid;
  logic [DEPTH-1:0][BANK_W-1:0]   nBank;
  logic [DEPTH-1:0][ROW_W-1:0]    nRow;
  logic [DEPTH-1:0][COL_W-1:0]    nCol;
  logic [DEPTH-1:0][LEFT_W-1:0]   nLeft;
  logic [NUM_BANKS-1:0][CNT_W-1:0] bankWait;
  logic [CNT_W-1:0]               rdWait;
  logic [SLOT_W:0]                fill;
  logic [SLOT_W-1:0]              wrIdx;
  logic                           popNow;
  logic                           pushNow;
  logic [BANK_W-1:0]              tgtBank;
  logic [ROW_W-1:0]               tgtRow;

  assign reqReady = !qValid[DEPTH-1];
  assign pushNow  = reqValid && reqReady;
  assign popNow   = strb.issue && strb.code == CMD_RD && strb.retire;
  assign tgtBank  = qBank[slot];
  assign tgtRow   = qRow[slot];
  assign rdBusy   = rdWait != '0;

  always_comb begin
    fill = '0;
    for (int i = 0; i < DEPTH; i++) fill = fill + (SLOT_W+1)'(qValid[i]);
  end
  assign wrIdx = SLOT_W'(fill - (SLOT_W+1)'(popNow));

  // queue: shift out on retire, advance column on a partial burst, append on push
  always_comb begin
    nValid = qValid; nBank = qBank; nRow = qRow; nCol = qCol; nLeft = qLeft;
    if (strb.issue && strb.code == CMD_RD) begin
      if (strb.retire) begin
        for (int i = 0; i < DEPTH-1; i++) begin
          nValid[i] = qValid[i+1]; nBank[i] = qBank[i+1]; nRow[i] = qRow[i+1];
          nCol[i]   = qCol[i+1];   nLeft[i] = qLeft[i+1];
        end
        nValid[DEPTH-1] = 1'b0;
      end else begin
        nCol[0]  = qCol[0] + COL_W'(BURST_LEN);
        nLeft[0] = qLeft[0] - LEFT_W'(1);
      end
    end
    if (pushNow) begin
      nValid[wrIdx] = 1'b1;      nBank[wrIdx] = reqBank; nRow[wrIdx] = reqRow;
      nCol[wrIdx]   = reqCol;    nLeft[wrIdx] = reqBursts;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qValid <= '0; qBank <= '0; qRow <= '0; qCol <= '0; qLeft <= '0;
    end else begin
      qValid <= nValid; qBank <= nBank; qRow <= nRow; qCol <= nCol; qLeft <= nLeft;
    end
  end

  // per-bank open row and delay counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankOpen <= '0; bankRow <= '0; bankWait <= '0;
    end else begin
      for (int k = 0; k < NUM_BANKS; k++) begin
        if (strb.issue && tgtBank == BANK_W'(k) && strb.code == CMD_PRE) begin
          bankOpen[k] <= 1'b0;
          bankWait[k] <= CNT_W'(T_RP - 1);
        end else if (strb.issue && tgtBank == BANK_W'(k) && strb.code == CMD_ACT) begin
          bankOpen[k] <= 1'b1;
          bankRow[k]  <= tgtRow;
          bankWait[k] <= CNT_W'(T_RCD - 1);
        end else if (bankWait[k] != '0) begin
          bankWait[k] <= bankWait[k] - CNT_W'(1);
        end
      end
    end
  end

  always_comb
    for (int k = 0; k < NUM_BANKS; k++) bankBusy[k] = bankWait[k] != '0;

  always_ff @(posedge clk) begin
    if (!rstN)                                  rdWait <= '0;
    else if (strb.issue && strb.code == CMD_RD) rdWait <= CNT_W'(T_RR - 1);
    else if (rdWait != '0)                      rdWait <= rdWait - CNT_W'(1);
  end

  // registered command output
  always_ff @(posedge clk) begin
    if (!rstN || !strb.issue) begin
      cmdCode <= CMD_NOP; cmdBank <= '0; cmdAddr <= '0;
    end else begin
      cmdCode <= strb.code;
      cmdBank <= tgtBank;
      case (strb.code)
        CMD_ACT: cmdAddr <= ADDR_W'(tgtRow);
        CMD_RD:  cmdAddr <= ADDR_W'(qCol[0]);
        default: cmdAddr <= '0;
      endcase
    end
  end

  // R3: precharge only goes to an open bank
  p_pre_open_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue && strb.code == CMD_PRE |-> bankOpen[tgtBank]);
  // R4: activate waits out the precharge delay on a closed bank
  p_act_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue && strb.code == CMD_ACT |-> bankWait[tgtBank] == '0 && !bankOpen[tgtBank]);
  // R5 and R6: a read targets the open row after both delays have expired
  p_read_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue && strb.code == CMD_RD |->
      bankOpen[tgtBank] && bankRow[tgtBank] == tgtRow && bankWait[tgtBank] == '0 && rdWait == '0);
  // R8: reads come only from the head entry
  p_read_head_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue && strb.code == CMD_RD |-> slot == '0 && qValid[0]);
  // R10: an accepted push adds one entry unless the head retired
  p_push_grow_r10: assert property (@(posedge clk) disable iff (!rstN)
    pushNow && !popNow |=> $countones(qValid) == $countones($past(qValid)) + 1);
  // R11: an idle cycle drives no bank or address
  p_nop_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == CMD_NOP |-> cmdBank == '0 && cmdAddr == '0);
endmodule

// File: rtl/bank_lookahead_sched.sv
module bank_lookahead_sched
  import sched_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int NUM_BANKS  = 4,
  parameter int ROW_W      = 8,
  parameter int COL_W      = 8,
  parameter int MAX_BURSTS = 4,
  parameter int BURST_LEN  = 4,
  parameter int T_RP       = 2,
  parameter int T_RCD      = 2,
  parameter int T_RR       = 2,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int LEFT_W = $clog2(MAX_BURSTS),
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [LEFT_W-1:0] reqBursts,
  output logic [1:0]        cmdCode,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr
);
  strobe_t                          strb;
  logic [SLOT_W-1:0]                slot;
  logic [DEPTH-1:0]                 qValid;
  logic [DEPTH-1:0][BANK_W-1:0]     qBank;
  logic [DEPTH-1:0][ROW_W-1:0]      qRow;
  logic [DEPTH-1:0][LEFT_W-1:0]     qLeft;
  logic [NUM_BANKS-1:0]             bankOpen;
  logic [NUM_BANKS-1:0][ROW_W-1:0]  bankRow;
  logic [NUM_BANKS-1:0]             bankBusy;
  logic                             rdBusy;
  cmd_e                             cmdCodeE;

  assign cmdCode = cmdCodeE;

  sched_ctrl #(
    .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .MAX_BURSTS(MAX_BURSTS)
  ) i_ctrl (
    .qValid(qValid), .qBank(qBank), .qRow(qRow), .qLeft(qLeft),
    .bankOpen(bankOpen), .bankRow(bankRow), .bankBusy(bankBusy), .rdBusy(rdBusy),
    .strb(strb), .slot(slot)
  );

  sched_dp #(
    .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W),
    .MAX_BURSTS(MAX_BURSTS), .BURST_LEN(BURST_LEN),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RR(T_RR)
  ) i_dp (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqBank(reqBank), .reqRow(reqRow),
    .reqCol(reqCol), .reqBursts(reqBursts),
    .strb(strb), .slot(slot),
    .qValid(qValid), .qBank(qBank), .qRow(qRow), .qLeft(qLeft),
    .bankOpen(bankOpen), .bankRow(bankRow), .bankBusy(bankBusy), .rdBusy(rdBusy),
    .cmdCode(cmdCodeE), .cmdBank(cmdBank), .cmdAddr(cmdAddr)
  );
endmodule

// File: tb/test_bank_lookahead_sched.sv
module test_bank_lookahead_sched;
  localparam int NOP = 0, PRE = 1, ACT = 2, RD = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [1:0] reqBank = '0;
  logic [7:0] reqRow = '0;
  logic [7:0] reqCol = '0;
  logic [1:0] reqBursts = '0;
  logic [1:0] cmdCode;
  logic [1:0] cmdBank;
  logic [7:0] cmdAddr;

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  bit done = 0;
  int trN = 0;
  int trCode [64];
  int trBank [64];
  int trAddr [64];
  int trCyc  [64];

  bank_lookahead_sched i_bank_lookahead_sched (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .reqBursts(reqBursts),
    .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdAddr(cmdAddr)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      nErr++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  // command trace, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN && cmdCode != 2'd0 && trN < 64) begin
      trCode[trN] = int'(cmdCode); trBank[trN] = int'(cmdBank);
      trAddr[trN] = int'(cmdAddr); trCyc[trN] = cyc;
      trN++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare trace entry idx with code/bank/addr and cycle offset from entry 0
  task automatic expectTr(input int idx, input int code, input int bank, input int addr,
                          input int off, input string tag);
    int act;
    int exp;
    exp = code * 1024 + bank * 256 + addr;
    if (idx >= trN) begin
      chk(0, {tag, " missing command"}, trN, idx + 1);
    end else begin
      act = trCode[idx] * 1024 + trBank[idx] * 256 + trAddr[idx];
      chk(act == exp, {tag, " code*1024+bank*256+addr"}, act, exp);
      chk(trCyc[idx] - trCyc[0] == off, {tag, " cycle offset"}, trCyc[idx] - trCyc[0], off);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    trN = 0;
  endtask

  task automatic push(input int b, input int r, input int c, input int n);
    reqValid = 1'b1; reqBank = 2'(b); reqRow = 8'(r); reqCol = 8'(c); reqBursts = 2'(n);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    chk(cmdCode == 2'd0, "R1 idle code", int'(cmdCode), 0);
    chk(cmdBank == 2'd0, "R1 idle bank", int'(cmdBank), 0);
    chk(cmdAddr == 8'd0, "R1 idle addr", int'(cmdAddr), 0);
    chk(reqReady == 1'b1, "R1 ready", int'(reqReady), 1);
  endtask

  task automatic testPageStates();
    doReset();
    push(1, 5, 8, 0);                       // closed bank
    settle();
    expectTr(0, ACT, 1, 5, 0, "R3 closed-bank ACT");
    expectTr(1, RD, 1, 8, 2, "R5 read after tRCD");
    chk(trN == 2, "R3 closed-bank count", trN, 2);
    trN = 0;
    push(1, 5, 0, 0);                       // page hit
    settle();
    expectTr(0, RD, 1, 0, 0, "R2 hit read only");
    chk(trN == 1, "R2 hit count", trN, 1);
    trN = 0;
    push(1, 7, 3, 0);                       // page miss
    settle();
    expectTr(0, PRE, 1, 0, 0, "R3 miss PRE");
    expectTr(1, ACT, 1, 7, 2, "R4 ACT after tRP");
    expectTr(2, RD, 1, 3, 4, "R5 miss read");
    chk(trN == 3, "R3 miss count", trN, 3);
  endtask

  task automatic testMultiBurst();
    doReset();
    push(2, 3, 0, 2);                       // three bursts
    settle();
    expectTr(0, ACT, 2, 3, 0, "R6 ACT");
    expectTr(1, RD, 2, 0, 2, "R6 burst0");
    expectTr(2, RD, 2, 4, 4, "R6 burst1");
    expectTr(3, RD, 2, 8, 6, "R6 burst2");
    chk(trN == 4, "R6 count", trN, 4);
  endtask

  task automatic testLookAhead();
    doReset();
    push(0, 1, 0, 0); push(1, 2, 0, 0); push(2, 3, 0, 0);
    settle();
    trN = 0;
    push(0, 1, 0, 3);                       // head: hit, four bursts
    push(1, 6, 1, 0);                       // miss
    push(2, 7, 2, 0);                       // miss
    push(3, 8, 3, 0);                       // closed
    settle();
    expectTr(0,  RD,  0, 0,  0,  "R8 head burst0");
    expectTr(1,  PRE, 1, 0,  1,  "R7 early PRE oldest younger");
    expectTr(2,  RD,  0, 4,  2,  "R6 head burst1");
    expectTr(3,  ACT, 1, 6,  3,  "R7 early ACT beats younger PRE");
    expectTr(4,  RD,  0, 8,  4,  "R6 head burst2");
    expectTr(5,  PRE, 2, 0,  5,  "R7 next eligible younger");
    expectTr(6,  RD,  0, 12, 6,  "R8 head last burst");
    expectTr(7,  ACT, 2, 7,  7,  "R7 early ACT bank2");
    expectTr(8,  RD,  1, 1,  8,  "R8 second request read");
    expectTr(9,  ACT, 3, 8,  9,  "R7 early ACT bank3");
    expectTr(10, RD,  2, 2,  10, "R8 third request read");
    expectTr(11, RD,  3, 3,  12, "R11 NOP gap then read");
  endtask

  task automatic testConflict();
    doReset();
    push(0, 1, 0, 0);
    settle();
    trN = 0;
    push(0, 1, 0, 1);                       // head keeps row 1 open
    push(0, 2, 5, 0);                       // younger wants row 2 on same bank
    settle();
    expectTr(0, RD,  0, 0, 0, "R9 head burst0");
    expectTr(1, RD,  0, 4, 2, "R9 row kept open");
    expectTr(2, PRE, 0, 0, 3, "R9 PRE after head retires");
    expectTr(3, ACT, 0, 2, 5, "R4 ACT spacing");
    expectTr(4, RD,  0, 5, 7, "R9 younger read");
  endtask

  task automatic testFull();
    int reads;
    doReset();
    push(0, 1, 0, 3);
    push(0, 2, 0, 0);
    push(0, 3, 0, 0);
    push(0, 4, 0, 0);
    chk(reqReady == 1'b0, "R10 ready low when full", int'(reqReady), 0);
    push(0, 1, 16, 0);
    repeat (80) @(negedge clk);
    expectTr(0, ACT, 0, 1, 0, "R9 head ACT");
    expectTr(1, RD,  0, 0, 2, "R9 no early PRE burst0");
    expectTr(2, RD,  0, 4, 4, "R9 no early PRE burst1");
    expectTr(3, RD,  0, 8, 6, "R9 no early PRE burst2");
    expectTr(4, RD,  0, 12, 8, "R9 no early PRE burst3");
    reads = 0;
    for (int i = 0; i < trN; i++) if (trCode[i] == RD) reads++;
    chk(reads == 8, "R10 all pushed reads issued", reads, 8);
    if (trN > 0) expectTr(trN - 1, RD, 0, 16, trCyc[trN-1] - trCyc[0], "R10 held push served last");
  endtask

  initial begin
    testReset();
    testPageStates();
    testMultiBurst();
    testLookAhead();
    testConflict();
    testFull();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule